// File: doc/BRIEF.md
# Wavefront Vector Floating-Point Comparator

This block evaluates one single-precision floating-point comparison predicate over a group of 64 operand pairs. The pairs arrive as 16-lane slices on four consecutive cycles. Each lane classifies its pair as exactly one of four relations: less, equal, greater or unordered. The chosen predicate then reduces that relation to one result bit. The bits of the four slices are packed into a 64-bit mask, with one bit per group element.

A caller raises `start` together with the first slice and presents the other three slices on the next three cycles. The predicate code and its signaling bit are captured together with the first slice. When the last slice has been sampled, the block pulses `done_o`. The completed mask and an invalid-operation flag are then held steady until the next group is accepted. The flag is an OR over every lane of every slice. It reports signaling NaN operands, and it also reports any NaN compared under a signaling predicate.

Top module: `vfc_wave_cmp`

## Requirements
- R1: After reset, `mask_o`, `done_o` and `invalid_o` are all zero.
- R2: A group is accepted when `start` is high while the block is idle. The slice sampled at that edge is pass 0, and passes 1, 2 and 3 are sampled on the three following edges. The result of lane j in pass k lands in mask bit 16k+j.
- R3: `done_o` is high for exactly one cycle. That cycle follows the edge that samples pass 3, and the complete mask is valid in it.
- R4: `pred_i` bits select relations, and the result is the OR of the selected ones: bit 0 less, bit 1 equal, bit 2 greater, bit 3 unordered. So code 0 is always false, 15 is always true, 13 is not-equal and 7 is ordered.
- R5: A NaN is a value whose exponent field is all ones and whose fraction is nonzero. When either operand is a NaN, the pair is unordered and is never less, equal or greater.
- R6: +0 and -0 compare equal. All other non-NaN values, including subnormals and infinities, are ordered by numeric value.
- R7: `invalid_o` is set when any lane of any pass sees a signaling NaN, meaning a NaN whose fraction MSB is 0. It is also set when any lane sees any NaN while the signaling bit `pred_sig_i` is 1. The flag is cleared when a new group is accepted.
- R8: The values of `pred_i` and `pred_sig_i` on cycles after pass 0 have no effect on the group.
- R9: A `start` raised while a group is in progress is ignored. After `done_o`, the mask and the flag hold their values until the next accepted start, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a group; presented with pass 0 |
| pred_i | input | 4 | Relation-select predicate code |
| pred_sig_i | input | 1 | 1 selects the signaling form of the predicate |
| a_slice_i | input | 512 | Sixteen operand-A values, lane j at bits 32j+31..32j |
| b_slice_i | input | 512 | Sixteen operand-B values, same lane layout |
| mask_o | output | 64 | Packed per-element result mask |
| done_o | output | 1 | One-cycle group-complete pulse |
| invalid_o | output | 1 | Invalid-operation flag for the last group |

## Verification
Two events can fall in the same cycle: a new `start`, and a pass that is still writing its slice of the current group. The bench provokes this by raising `start` with a different predicate during pass 2. It then requires the mask of the first group, the `done_o` pulse at its normal cycle, and no second pulse afterwards. A related collision is a predicate change on the same edge that samples a later pass. This is judged by comparing the mask against the predicate that was latched at pass 0.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
   // relation bit positions; the predicate code uses the same positions
   localparam int REL_LT = 0;
   localparam int REL_EQ = 1;
   localparam int REL_GT = 2;
   localparam int REL_UN = 3;
   localparam int REL_W  = 4;

   typedef logic [REL_W-1:0] rel_vec_t;

   function automatic logic pred_hit(input rel_vec_t rel, input rel_vec_t pred);
      return |(rel & pred);
   endfunction
endpackage

// File: rtl/vfc_lane_cmp.sv
module vfc_lane_cmp
   import vfc_pkg::*;
#(
   parameter int FW   = 32,
   parameter int EXPW = 8
) (
   input  logic [FW-1:0] a_i,
   input  logic [FW-1:0] b_i,
   output rel_vec_t      rel_o,
   output logic          snan_o,
   output logic          nan_o
);
   localparam int MANW = FW - 1 - EXPW;
   localparam int MAGW = FW - 1;

   generate
      if (MANW < 2) begin : g_bad_fmt
         $error("vfc_lane_cmp: fraction field too narrow");
      end
   endgenerate

   logic [MAGW-1:0] mag_a, mag_b;
   logic            sgn_a, sgn_b;
   logic            nan_a, nan_b, snan_a, snan_b;
   logic            unord, both_zero, eq, lt, gt;

   always_comb begin
      sgn_a  = a_i[FW-1];
      sgn_b  = b_i[FW-1];
      mag_a  = a_i[MAGW-1:0];
      mag_b  = b_i[MAGW-1:0];
      nan_a  = (&a_i[FW-2 -: EXPW]) && (|a_i[MANW-1:0]);
      nan_b  = (&b_i[FW-2 -: EXPW]) && (|b_i[MANW-1:0]);
      snan_a = nan_a && !a_i[MANW-1];
      snan_b = nan_b && !b_i[MANW-1];
      unord  = nan_a || nan_b;
      both_zero = (mag_a == '0) && (mag_b == '0);
      eq = !unord && (both_zero || (a_i == b_i));
      unique case ({sgn_a, sgn_b})
         2'b00:   lt = mag_a < mag_b;
         2'b11:   lt = mag_a > mag_b;
         2'b10:   lt = !both_zero;
         default: lt = 1'b0;
      endcase
      lt = lt && !unord;
      gt = !unord && !eq && !lt;
      rel_o = '0;
      rel_o[REL_LT] = lt;
      rel_o[REL_EQ] = eq;
      rel_o[REL_GT] = gt;
      rel_o[REL_UN] = unord;
      snan_o = snan_a || snan_b;
      nan_o  = unord;
   end
endmodule

// File: rtl/vfc_pass_ctrl.sv
module vfc_pass_ctrl #(
   parameter int PASSES = 4,
   localparam int PW    = (PASSES > 1) ? $clog2(PASSES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          accept_o,
   output logic          busy_o,
   output logic [PW-1:0] pass_o,
   output logic          done_o
);
   localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

   generate
      if (PASSES < 2) begin : g_bad_passes
         $error("vfc_pass_ctrl: at least two passes are needed");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic          busy_q, done_q;

   assign accept_o = start_i && !busy_q;
   assign busy_o   = busy_q;
   assign pass_o   = busy_q ? cnt_q : '0;
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= PW'(1);
         end else if (busy_q) begin
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + PW'(1);
            end
         end
      end
   end

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R3
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == LAST) |=> done_q);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> (busy_q && !done_q));
endmodule

// File: rtl/vfc_wave_cmp.sv
module vfc_wave_cmp
   import vfc_pkg::*;
#(
   parameter int LANES = 16,
   parameter int GROUP = 64,
   parameter int FW    = 32,
   parameter int EXPW  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [3:0]          pred_i,
   input  logic                pred_sig_i,
   input  logic [LANES*FW-1:0] a_slice_i,
   input  logic [LANES*FW-1:0] b_slice_i,
   output logic [GROUP-1:0]    mask_o,
   output logic                done_o,
   output logic                invalid_o
);
   localparam int PASSES = GROUP / LANES;
   localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;

   generate
      if (GROUP % LANES != 0) begin : g_bad_group
         $error("vfc_wave_cmp: GROUP must be a multiple of LANES");
      end
      if (REL_W != 4) begin : g_bad_rel
         $error("vfc_wave_cmp: predicate code width mismatch");
      end
   endgenerate

   logic          accept, busy;
   logic [PW-1:0] pass_idx;
   logic          wr_en;

   vfc_pass_ctrl #(.PASSES(PASSES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (busy),
      .pass_o   (pass_idx),
      .done_o   (done_o)
   );

   assign wr_en = accept || busy;

   // predicate capture at pass 0
   rel_vec_t pred_q, pred_eff;
   logic     sig_q, sig_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_q <= '0;
         sig_q  <= 1'b0;
      end else if (accept) begin
         pred_q <= pred_i;
         sig_q  <= pred_sig_i;
      end
   end

   assign pred_eff = accept ? rel_vec_t'(pred_i) : pred_q;
   assign sig_eff  = accept ? pred_sig_i : sig_q;

   // lane array
   rel_vec_t         rel_l [LANES];
   logic [LANES-1:0] hit_l, snan_l, nan_l;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      vfc_lane_cmp #(.FW(FW), .EXPW(EXPW)) u_cmp (
         .a_i    (a_slice_i[l*FW +: FW]),
         .b_i    (b_slice_i[l*FW +: FW]),
         .rel_o  (rel_l[l]),
         .snan_o (snan_l[l]),
         .nan_o  (nan_l[l])
      );
      assign hit_l[l] = pred_hit(rel_l[l], pred_eff);

      // R5
      rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> $onehot(rel_l[l]));
   end

   logic slice_inv;
   assign slice_inv = (|snan_l) || (sig_eff && (|nan_l));

   // mask and flag storage
   logic [GROUP-1:0] mask_q;
   logic             inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         inv_q  <= 1'b0;
      end else if (wr_en) begin
         for (int p = 0; p < PASSES; p++) begin
            if (PW'(p) == pass_idx) begin
               mask_q[p*LANES +: LANES] <= hit_l;
            end else if (accept) begin
               mask_q[p*LANES +: LANES] <= '0;
            end
         end
         inv_q <= slice_inv || (busy && inv_q);
      end
   end

   assign mask_o    = mask_q;
   assign invalid_o = inv_q;

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_i) |=> ($stable(mask_o) && $stable(invalid_o)));
   // R7
   snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (|snan_l)) |=> invalid_o);
   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && invalid_o) |=> invalid_o);
endmodule

// File: tb/vfc_wave_cmp_tb_top.sv
module vfc_wave_cmp_tb_top;
   localparam int LANES = 16;
   localparam int GROUP = 64;
   localparam int FW    = 32;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  pred;
      logic        sig;
      logic        exp_bit;
      logic        exp_inv;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t TBL [NV] = '{
      '{32'h3F800000, 32'h40000000, 4'd1,  1'b0, 1'b1, 1'b0},
      '{32'h40000000, 32'h3F800000, 4'd1,  1'b0, 1'b0, 1'b0},
      '{32'h3F800000, 32'h3F800000, 4'd2,  1'b0, 1'b1, 1'b0},
      '{32'h00000000, 32'h80000000, 4'd2,  1'b0, 1'b1, 1'b0},
      '{32'h80000000, 32'h00000000, 4'd1,  1'b0, 1'b0, 1'b0},
      '{32'hBF800000, 32'h3F800000, 4'd1,  1'b0, 1'b1, 1'b0},
      '{32'hC0000000, 32'hBF800000, 4'd1,  1'b0, 1'b1, 1'b0},
      '{32'hFF800000, 32'h7F800000, 4'd6,  1'b0, 1'b0, 1'b0},
      '{32'h7F800000, 32'h40000000, 4'd4,  1'b0, 1'b1, 1'b0},
      '{32'h7FC00000, 32'h3F800000, 4'd8,  1'b0, 1'b1, 1'b0},
      '{32'h7FC00000, 32'h3F800000, 4'd2,  1'b0, 1'b0, 1'b0},
      '{32'h7FC00000, 32'h3F800000, 4'd13, 1'b0, 1'b1, 1'b0},
      '{32'h7FC00000, 32'h3F800000, 4'd1,  1'b1, 1'b0, 1'b1},
      '{32'h7FA00000, 32'h3F800000, 4'd15, 1'b0, 1'b1, 1'b1},
      '{32'h3F800000, 32'h7FA00000, 4'd7,  1'b0, 1'b0, 1'b1},
      '{32'h3F800000, 32'h40000000, 4'd0,  1'b0, 1'b0, 1'b0},
      '{32'h3F800000, 32'h40000000, 4'd15, 1'b0, 1'b1, 1'b0},
      '{32'h3F800000, 32'h40000000, 4'd9,  1'b0, 1'b1, 1'b0},
      '{32'h40000000, 32'h3F800000, 4'd12, 1'b0, 1'b1, 1'b0},
      '{32'h00000001, 32'h00000000, 4'd4,  1'b0, 1'b1, 1'b0},
      '{32'h3F800000, 32'h3F800000, 4'd5,  1'b0, 1'b0, 1'b0},
      '{32'h3F800000, 32'h40000000, 4'd3,  1'b1, 1'b1, 1'b0},
      '{32'h80000001, 32'h00000000, 4'd1,  1'b0, 1'b1, 1'b0},
      '{32'h40000000, 32'h40000000, 4'd14, 1'b0, 1'b1, 1'b0},
      '{32'h40000000, 32'h3F800000, 4'd11, 1'b0, 1'b0, 1'b0},
      '{32'h7FC00000, 32'h7FC00000, 4'd7,  1'b0, 1'b0, 1'b0}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic [3:0]          pred_i = '0;
   logic                pred_sig_i = 1'b0;
   logic [LANES*FW-1:0] a_slice_i = '0;
   logic [LANES*FW-1:0] b_slice_i = '0;
   logic [GROUP-1:0]    mask_o;
   logic                done_o;
   logic                invalid_o;

   int checks = 0;
   int failures = 0;
   logic [31:0] a_arr [GROUP];
   logic [31:0] b_arr [GROUP];
   logic [GROUP+1:0] got;

   always #4 clk = ~clk;

   vfc_wave_cmp dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .pred_i     (pred_i),
      .pred_sig_i (pred_sig_i),
      .a_slice_i  (a_slice_i),
      .b_slice_i  (b_slice_i),
      .mask_o     (mask_o),
      .done_o     (done_o),
      .invalid_o  (invalid_o)
   );

   function automatic logic [31:0] fnum(input int m);
      return {1'b0, 8'd128, 23'(m)};
   endfunction

   task automatic chk(input string tag, input logic [GROUP+1:0] act, input logic [GROUP+1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic fill(input logic [31:0] a, input logic [31:0] b);
      for (int e = 0; e < GROUP; e++) begin
         a_arr[e] = a;
         b_arr[e] = b;
      end
   endtask

   task automatic fill_ramp(input int thr);
      for (int e = 0; e < GROUP; e++) begin
         a_arr[e] = fnum(e);
         b_arr[e] = fnum(thr);
      end
   endtask

   // drives one group; after pass 0 the predicate becomes p_late and the
   // signaling bit flips; mid raises start again during pass 2
   task automatic run_group(input logic [3:0] p, input logic s,
                            input logic [3:0] p_late, input logic mid);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         start_i    = (k == 0) || (mid && k == 2);
         pred_i     = (k == 0) ? p : p_late;
         pred_sig_i = (k == 0) ? s : ~s;
         for (int l = 0; l < LANES; l++) begin
            a_slice_i[l*FW +: FW] = a_arr[k*LANES + l];
            b_slice_i[l*FW +: FW] = b_arr[k*LANES + l];
         end
      end
      @(negedge clk);
      start_i = 1'b0;
      got = {done_o, invalid_o, mask_o};
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [GROUP-1:0] m;
      repeat (3) @(negedge clk);
      // R1
      chk("R1 reset state", {done_o, invalid_o, mask_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {done_o, invalid_o, mask_o}, '0);

      // table walk: R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         fill(TBL[i].a, TBL[i].b);
         run_group(TBL[i].pred, TBL[i].sig, TBL[i].pred, 1'b0);
         chk($sformatf("R4 R5 R6 R7 vector %0d", i), got,
             {1'b1, TBL[i].exp_inv, {GROUP{TBL[i].exp_bit}}});
      end

      // R2 placement: element e holds e, threshold 37
      fill_ramp(37);
      m = (64'd1 << 37) - 64'd1;
      run_group(4'd1, 1'b0, 4'd1, 1'b0);
      chk("R2 less placement", got, {2'b10, m});
      @(negedge clk);
      // R3
      chk("R3 done drops after one cycle", {63'd0, done_o}, '0);
      run_group(4'd4, 1'b0, 4'd4, 1'b0);
      chk("R2 greater placement", got, {2'b10, ~((64'd1 << 38) - 64'd1)});

      // R8: predicate changed after pass 0
      run_group(4'd2, 1'b0, 4'd1, 1'b0);
      chk("R8 late predicate ignored", got, {2'b10, 64'd1 << 37});

      // R9: start while busy ignored
      run_group(4'd1, 1'b0, 4'd4, 1'b1);
      chk("R9 mid start ignored", got, {2'b10, m});
      @(negedge clk);
      chk("R9 R3 no second done", {63'd0, done_o}, '0);
      fill(32'h7FA00000, 32'h7FC00000);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         pred_i     = 4'd15;
         pred_sig_i = 1'b1;
         a_slice_i  = '1;
      end
      @(negedge clk);
      chk("R9 hold after done", {done_o, invalid_o, mask_o}, {2'b00, m});

      // R7: sNaN only in element 63 (pass 3, lane 15)
      fill(32'h3F800000, 32'h40000000);
      a_arr[63] = 32'h7FA00000;
      run_group(4'd1, 1'b0, 4'd1, 1'b0);
      chk("R7 R5 sNaN in last pass", got, {2'b11, ~(64'd1 << 63)});

      // R7: quiet NaN at element 20 under signaling predicate
      fill(32'h3F800000, 32'h40000000);
      a_arr[20] = 32'h7FC00000;
      run_group(4'd1, 1'b1, 4'd1, 1'b0);
      chk("R7 R8 qNaN signaling pass 1", got, {2'b11, ~(64'd1 << 20)});

      // R7: quiet NaN, quiet predicate; late sig flip must not count
      run_group(4'd1, 1'b0, 4'd1, 1'b0);
      chk("R7 R8 qNaN quiet", got, {2'b10, ~(64'd1 << 20)});

      // R7: flag cleared by clean group
      fill(32'h3F800000, 32'h40000000);
      run_group(4'd1, 1'b0, 4'd1, 1'b0);
      chk("R7 flag cleared on new group", got, {2'b10, {GROUP{1'b1}}});

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule